// File: doc/BRIEF.md
# Per-Phase Target Response Attribute Sequencer

This block tells a bus target how to answer each data phase. A table of attribute entries, written while the bus is quiet, holds one entry per data phase. Each entry sets how many wait cycles pass before the target signals ready, or that ready never comes. It also sets how the phase terminates, whether wide (64-bit) data is accepted, and which error and parity faults are forced for that phase. A read pointer steps through the table, one entry per accepted data phase, and wraps to entry 0 after a programmable last index.

The bus side is reduced to three strobes: an address-phase strobe opens a transaction, a data-phase strobe starts a phase, and an end strobe closes the transaction from the master side. A mode input chooses what happens to the pointer at each new transaction. It either goes back to entry 0, so every transaction replays the same script, or it keeps its place, so the target behaves like a FIFO that remembers where it stopped. The answer comes back as a one-cycle ready pulse, with the attributes of the phase held on registered outputs.

Top module: `tgt_phase_seq`

## Requirements
- R1: After a synchronous reset, `txn_active` and `rsp_ready` are 0 and the first phase of the first transaction uses entry 0.
- R2: An entry's wait field (bits [4:0]) holding W = 0 to 30 makes `rsp_ready` a one-cycle pulse in cycle c+1+W, where c is the cycle in which the data strobe was accepted. A field value of 31 behaves as 30.
- R3: With the hang bit (bit 5) set, `rsp_ready` never pulses for that phase. The phase stays pending until `txn_end`.
- R4: While `rsp_ready` is high, the outputs show the accepted entry's fields. Termination is bits [7:6] (0 none, 1 retry, 2 disconnect, 3 target abort), wide-data accept is bit 8, error assertion is bit 9, parity error is bit 10, low parity invert is bit 11 and high parity invert is bit 12. These outputs hold their values until the next phase is accepted.
- R5: A phase whose termination is not "none" ends the transaction: `txn_active` is low in the cycle `rsp_ready` pulses. The pointer has already moved past that entry.
- R6: Each accepted data phase advances the pointer by one. When the pointer is at or beyond `cfg_last`, it goes to 0 instead.
- R7: When `cfg_continue` is 0, an accepted address strobe sets the pointer to 0. When it is 1, the pointer keeps its value across transactions.
- R8: A table write is ignored while `txn_active` or `addr_stb` is high.
- R9: A data strobe is ignored when no transaction is active, while the previous phase is still pending, or in a `txn_end` cycle. An address strobe is ignored while a transaction is active.
- R10: `txn_end` clears `txn_active` and discards any pending phase, including a hung one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | $clog2(DEPTH) | Table entry written |
| cfg_entry | input | 13 | Attribute entry value |
| cfg_last | input | $clog2(DEPTH) | Index of the last programmed entry |
| cfg_continue | input | 1 | 1: pointer kept across transactions; 0: restart at 0 |
| addr_stb | input | 1 | Address phase, opens a transaction |
| data_stb | input | 1 | Start of a data phase |
| txn_end | input | 1 | Master closes the transaction |
| txn_active | output | 1 | Transaction in progress |
| rsp_ready | output | 1 | Target ready pulse for the phase |
| rsp_term | output | 2 | Termination of the phase |
| rsp_ack64 | output | 1 | Wide data accepted |
| rsp_serr | output | 1 | Force error assertion |
| rsp_perr | output | 1 | Force parity error |
| rsp_inv_par_lo | output | 1 | Invert low parity bit |
| rsp_inv_par_hi | output | 1 | Invert high parity bit |

## Verification
The assertions assume that `cfg_last` and `cfg_continue` change only while no transaction is active, because the wrap and restart checks compare the pointer against their current values. They also assume that `addr_stb` and `txn_end` are never high in the same cycle. The stimulus changes these settings only between transactions and never pairs the two strobes. It does deliberately send strobes and writes that the block must ignore: writes during a transaction, a write in the same cycle as an address strobe, data strobes while a phase is pending, and data strobes after a termination.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    TERM_NONE  = 2'd0,
    TERM_RETRY = 2'd1,
    TERM_DISC  = 2'd2,
    TERM_ABORT = 2'd3
  } term_e;

  typedef struct packed {
    logic       inv_hi;
    logic       inv_lo;
    logic       perr;
    logic       serr;
    logic       ack64;
    term_e      term;
    logic       hang;
    logic [4:0] waits;
  } attr_t;

  localparam int unsigned ATTR_W = $bits(attr_t);
  localparam logic [4:0] MAX_WAITS = 5'd30;
endpackage

// File: rtl/tps_attr_ram.sv
module tps_attr_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 13,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tps_ptr_ctrl.sv
module tps_ptr_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_acc,
  input  logic          data_acc,
  input  logic          txn_end,
  input  logic          term_end,
  input  logic          cfg_continue,
  input  logic [AW-1:0] cfg_last,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_nxt,
  output logic          txn_active
);
  always_comb begin
    ptr_nxt = ptr;
    if (rst) ptr_nxt = '0;
    else if (addr_acc && !cfg_continue) ptr_nxt = '0;
    else if (data_acc) ptr_nxt = (ptr >= cfg_last) ? '0 : ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    ptr <= ptr_nxt;
    if (rst) txn_active <= 1'b0;
    else if (txn_end) txn_active <= 1'b0;
    else if (addr_acc) txn_active <= 1'b1;
    else if (term_end) txn_active <= 1'b0;
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ptr >= cfg_last) |=> (ptr == '0));
  assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ptr < cfg_last) |=> (ptr == $past(ptr) + AW'(1)));
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (addr_acc && !cfg_continue) |=> (ptr == '0));
  assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (addr_acc && cfg_continue) |=> $stable(ptr));
endmodule

// File: rtl/tps_phase_timer.sv
module tps_phase_timer
  import tps_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  abort,
  input  logic  accept,
  input  attr_t entry,
  output logic  busy,
  output logic  ready,
  output logic  term_end,
  output attr_t attr_q
);
  logic [4:0] cnt;
  logic       hang_q;
  logic [4:0] w_eff;
  logic       fire;
  term_e      fire_term;

  always_comb begin
    w_eff = (entry.waits > MAX_WAITS) ? MAX_WAITS : entry.waits;
    if (abort) fire = 1'b0;
    else if (accept) fire = !entry.hang && (w_eff == 5'd0);
    else fire = busy && !hang_q && (cnt == 5'd1);
    fire_term = accept ? entry.term : attr_q.term;
    term_end  = fire && (fire_term != TERM_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ready  <= 1'b0;
      cnt    <= '0;
      hang_q <= 1'b0;
      attr_q <= '0;
    end else begin
      ready <= fire;
      if (abort) begin
        busy   <= 1'b0;
        hang_q <= 1'b0;
      end else if (accept) begin
        attr_q <= entry;
        hang_q <= entry.hang;
        busy   <= entry.hang || (w_eff != 5'd0);
        cnt    <= w_eff;
      end else if (busy && !hang_q) begin
        if (cnt == 5'd1) busy <= 1'b0;
        else cnt <= cnt - 5'd1;
      end
    end
  end

  // Checker: cycles since the last accepted phase, compared at the ready pulse.
  logic [4:0] elapsed;
  logic [4:0] exp_w;
  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      exp_w   <= '0;
    end else if (accept) begin
      elapsed <= '0;
      exp_w   <= w_eff;
    end else if (elapsed != 5'd31) begin
      elapsed <= elapsed + 5'd1;
    end
  end

  assert_wait_count_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (elapsed == exp_w));
  assert_hang_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && hang_q) |-> !ready);
  assert_attr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(attr_q));
endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tps_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_idx,
  input  logic [ATTR_W-1:0] cfg_entry,
  input  logic [AW-1:0]     cfg_last,
  input  logic              cfg_continue,
  input  logic              addr_stb,
  input  logic              data_stb,
  input  logic              txn_end,
  output logic              txn_active,
  output logic              rsp_ready,
  output logic [1:0]        rsp_term,
  output logic              rsp_ack64,
  output logic              rsp_serr,
  output logic              rsp_perr,
  output logic              rsp_inv_par_lo,
  output logic              rsp_inv_par_hi
);
  logic              wr_ok, addr_acc, data_acc, busy, term_end;
  logic [AW-1:0]     ptr, ptr_nxt;
  logic [ATTR_W-1:0] rd_word;
  attr_t             attr_q;

  assign wr_ok    = cfg_we && !txn_active && !addr_stb;
  assign addr_acc = addr_stb && !txn_active && !txn_end;
  assign data_acc = data_stb && txn_active && !busy && !txn_end;

  tps_attr_ram #(.DEPTH(DEPTH), .WIDTH(ATTR_W)) u_ram (
    .clk(clk), .we(wr_ok), .waddr(cfg_idx), .wdata(cfg_entry),
    .raddr(ptr_nxt), .rdata(rd_word)
  );

  tps_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .addr_acc(addr_acc), .data_acc(data_acc),
    .txn_end(txn_end), .term_end(term_end), .cfg_continue(cfg_continue),
    .cfg_last(cfg_last), .ptr(ptr), .ptr_nxt(ptr_nxt), .txn_active(txn_active)
  );

  tps_phase_timer u_timer (
    .clk(clk), .rst(rst), .abort(txn_end), .accept(data_acc),
    .entry(attr_t'(rd_word)), .busy(busy), .ready(rsp_ready),
    .term_end(term_end), .attr_q(attr_q)
  );

  assign rsp_term       = attr_q.term;
  assign rsp_ack64      = attr_q.ack64;
  assign rsp_serr       = attr_q.serr;
  assign rsp_perr       = attr_q.perr;
  assign rsp_inv_par_lo = attr_q.inv_lo;
  assign rsp_inv_par_hi = attr_q.inv_hi;

  assert_term_closes_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready && rsp_term != 2'd0) |-> !txn_active);
  assert_end_closes_R10: assert property (@(posedge clk) disable iff (rst)
    txn_end |=> !txn_active);
endmodule

// File: tb/test_tgt_phase_seq.sv
module test_tgt_phase_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic [12:0] cfg_entry = '0;
  logic [7:0]  cfg_last = 8'd5;
  logic        cfg_continue = 1'b0;
  logic        addr_stb = 1'b0, data_stb = 1'b0, txn_end = 1'b0;
  logic        txn_active, rsp_ready, rsp_ack64, rsp_serr, rsp_perr;
  logic        rsp_inv_par_lo, rsp_inv_par_hi;
  logic [1:0]  rsp_term;

  tgt_phase_seq i_tgt_phase_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
    .cfg_last(cfg_last), .cfg_continue(cfg_continue), .addr_stb(addr_stb),
    .data_stb(data_stb), .txn_end(txn_end), .txn_active(txn_active),
    .rsp_ready(rsp_ready), .rsp_term(rsp_term), .rsp_ack64(rsp_ack64),
    .rsp_serr(rsp_serr), .rsp_perr(rsp_perr), .rsp_inv_par_lo(rsp_inv_par_lo),
    .rsp_inv_par_hi(rsp_inv_par_hi)
  );

  always #10 clk = ~clk;

  int    checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit    run = 1'b0;

  // Behavioural reference model
  int tbl [256];
  int m_ptr = 0, m_rem = 0, m_cur = 0;
  bit m_act = 0, m_busy = 0, m_hang = 0, m_rdy = 0;

  task automatic fire_model();
    m_rdy = 1'b1;
    if (((m_cur >> 6) & 3) != 0) m_act = 1'b0;
  endtask

  always @(posedge clk) begin
    bit wr, aa, da;
    int w;
    cyc++;
    if (rst) begin
      m_act = 0; m_busy = 0; m_hang = 0; m_ptr = 0; m_rdy = 0;
    end else begin
      wr = cfg_we && !m_act && !addr_stb;
      aa = addr_stb && !m_act && !txn_end;
      da = data_stb && m_act && !m_busy && !txn_end;
      m_rdy = 0;
      if (txn_end) begin
        m_act = 0; m_busy = 0; m_hang = 0;
      end else if (aa) begin
        m_act = 1;
        if (!cfg_continue) m_ptr = 0;
      end else if (da) begin
        m_cur = tbl[m_ptr];
        m_ptr = (m_ptr >= int'(cfg_last)) ? 0 : m_ptr + 1;
        w = m_cur & 31;
        if (w > 30) w = 30;
        if ((m_cur >> 5) & 1) begin m_busy = 1; m_hang = 1; end
        else if (w == 0) fire_model();
        else begin m_busy = 1; m_hang = 0; m_rem = w; end
      end else if (m_busy && !m_hang) begin
        if (m_rem == 1) begin m_busy = 0; fire_model(); end
        else m_rem--;
      end
      if (wr) tbl[cfg_idx] = int'(cfg_entry);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog %s: cycles %0d expected below 20000", tag, cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    int act_f, exp_f;
    if (run) begin
      checks++;
      if (rsp_ready !== m_rdy) begin
        fails++;
        $display("FAIL %s ready: got %0b expected %0b (cycle %0d)", tag, rsp_ready, m_rdy, cyc);
      end
      checks++;
      if (txn_active !== m_act) begin
        fails++;
        $display("FAIL %s active: got %0b expected %0b (cycle %0d)", tag, txn_active, m_act, cyc);
      end
      if (m_rdy) begin
        checks++;
        act_f = {rsp_inv_par_hi, rsp_inv_par_lo, rsp_perr, rsp_serr, rsp_ack64, rsp_term};
        exp_f = (m_cur >> 6) & 127;
        if (act_f != exp_f) begin
          fails++;
          $display("FAIL %s R4 fields: got %0h expected %0h", tag, act_f, exp_f);
        end
      end
    end
  end

  function automatic int ent(int w, int h, int t, int a, int s, int p, int lo, int hi);
    return w | (h << 5) | (t << 6) | (a << 8) | (s << 9) | (p << 10) | (lo << 11) | (hi << 12);
  endfunction

  task automatic wr_entry(int idx, int e);
    @(negedge clk); cfg_we = 1; cfg_idx = 8'(idx); cfg_entry = 13'(e);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic open_txn();
    @(negedge clk); addr_stb = 1; @(negedge clk); addr_stb = 0;
  endtask
  task automatic close_txn();
    @(negedge clk); txn_end = 1; @(negedge clk); txn_end = 0;
  endtask
  task automatic phase();
    @(negedge clk); data_stb = 1; @(negedge clk); data_stb = 0;
    for (int i = 0; i < 45; i++) begin
      if (rsp_ready || !txn_active) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    run = 1;
    tag = "R1";
    checks++;
    if (rsp_ready !== 1'b0 || txn_active !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got ready %0b active %0b expected 0 0", rsp_ready, txn_active);
    end
    wr_entry(0, ent(0, 0, 0, 1, 0, 0, 0, 0));
    wr_entry(1, ent(1, 0, 0, 0, 1, 0, 0, 0));
    wr_entry(2, ent(5, 0, 0, 0, 0, 1, 1, 0));
    wr_entry(3, ent(30, 0, 0, 0, 0, 0, 0, 1));
    wr_entry(4, ent(31, 0, 0, 1, 1, 1, 0, 0));
    wr_entry(5, ent(2, 0, 0, 0, 0, 0, 1, 1));
    wr_entry(6, ent(0, 0, 1, 0, 1, 0, 0, 0));
    wr_entry(7, ent(3, 0, 3, 1, 0, 1, 0, 0));
    wr_entry(8, ent(4, 1, 0, 0, 0, 0, 0, 0));
    wr_entry(9, ent(1, 0, 2, 0, 0, 0, 1, 0));
    // First transaction starts at entry 0 (R1), timing R2, fields R4, wrap R6
    tag = "R1/R2/R4/R6";
    open_txn();
    for (int k = 0; k < 8; k++) phase();
    close_txn();
    tag = "R7 restart";
    open_txn(); phase(); phase(); close_txn();
    tag = "R7 continue";
    @(negedge clk); cfg_continue = 1;
    open_txn(); phase(); phase(); close_txn();
    open_txn(); phase(); close_txn();
    // pointer at 5: strobes while pending or idle, address strobe while active
    tag = "R9";
    @(negedge clk); cfg_last = 8'd9;
    open_txn();
    @(negedge clk); data_stb = 1; @(negedge clk); @(negedge clk); data_stb = 0;
    addr_stb = 1; @(negedge clk); addr_stb = 0;
    repeat (3) @(negedge clk);
    tag = "R5 retry";
    phase();
    tag = "R9 after end";
    phase();
    tag = "R5 abort";
    open_txn(); phase();
    tag = "R3/R10 hang";
    open_txn(); phase(); close_txn();
    tag = "R10";
    phase();
    tag = "R5/R6 disconnect wrap";
    open_txn(); phase();
    @(negedge clk); cfg_continue = 0;
    tag = "R8";
    open_txn();
    wr_entry(0, ent(2, 0, 0, 0, 0, 0, 0, 1));
    phase(); close_txn();
    @(negedge clk); cfg_we = 1; addr_stb = 1; cfg_idx = 8'd0;
    cfg_entry = 13'(ent(3, 0, 0, 0, 1, 1, 1, 1));
    @(negedge clk); cfg_we = 0; addr_stb = 0;
    phase(); close_txn();
    wr_entry(0, ent(3, 0, 0, 0, 1, 1, 1, 1));
    open_txn(); phase(); phase(); close_txn();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule